// File: doc/BRIEF.md
# UART Banked Configuration Register Decoder

This block is the host-side configuration front end of a UART. A host issues single-cycle read or write strobes with a 3-bit address and an 8-bit data byte. The block keeps the line control byte, the feature control byte, the two integer divisor bytes and a 6-bit fractional divisor. It feeds the divisor values and the enhanced-function enable straight to the baud generator.

The meaning of an address depends on the line control byte it holds. There are three banks:

- **Normal bank** (line control bit 7 clear): only the line control byte is local.
- **Divisor bank** (bit 7 set, value not the key): the divisor bytes and the fractional divisor are local.
- **Feature bank** (value equal to the key 0xBF): the feature byte is local.

Accesses that no local register claims go out unchanged as pass-through strobes. Logic elsewhere (data, status, interrupt registers) decodes them against the same address bus.

Top module: `uart_cfg_bank`

## Requirements
- R1: After reset the line control byte, the feature byte, both divisor bytes and the fractional divisor are all zero. `div_update` is low.
- R2: Address 3 reaches the line control byte in every bank, for both reads and writes. Its value is always present on `lcr_q`.
- R3: While the line control byte equals 0xBF, address 2 reads and writes the feature byte. `enh_en` equals bit 4 of that byte.
- R4: While line control bit 7 is set and the byte is not 0xBF, address 0 reaches divisor bits 7:0 and address 1 reaches divisor bits 15:8. The full 16-bit divisor appears on `div_int`.
- R5: In the divisor bank, with `enh_en` high, a write to address 7 stores `wdata[5:0]` into the fractional divisor. A read of address 7 returns the stored value with bits 7:6 zero.
- R6: In the divisor bank, with `enh_en` low, a write to address 7 leaves the fractional divisor unchanged and produces no `div_update` pulse.
- R7: In the normal bank, accesses to addresses 0, 1, 2 and 7 leave every configuration register unchanged. They raise `pt_wr` or `pt_rd` in the same cycle as the strobe.
- R8: Addresses 4, 5 and 6 always pass through. So does address 2 in the divisor bank, and addresses 0, 1 and 7 in the feature bank.
- R9: Every accepted write to a divisor byte or to the fractional divisor makes `div_update` high for exactly the one cycle after the write edge.
- R10: `rdata` shows the addressed local register in the cycle `rd_en` is high. It is zero whenever the read is passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| pt_wr | output | 1 | Write strobe passed on to external registers |
| pt_rd | output | 1 | Read strobe passed on to external registers |
| lcr_q | output | 8 | Current line control byte |
| enh_en | output | 1 | Enhanced-function enable |
| div_int | output | 16 | Integer baud divisor |
| div_frac | output | 6 | Fractional divisor in 1/64 steps |
| div_update | output | 1 | One-cycle pulse after a divisor change |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that `addr` and `wdata` are stable while a strobe is high.

The stimulus tasks raise only one strobe at a time, and they hold address and data for the whole cycle. They walk the line control byte through the normal, divisor and feature banks. In each bank they probe both the claimed addresses and the passed-through ones.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
  typedef enum logic [1:0] {MODE_NORM, MODE_DIV, MODE_KEY} mode_e;
  typedef enum logic [2:0] {SEL_PASS, SEL_LCR, SEL_EFR, SEL_DLL, SEL_DLH, SEL_DLF} sel_e;
  localparam logic [2:0] ADR_DLL = 3'd0;
  localparam logic [2:0] ADR_DLH = 3'd1;
  localparam logic [2:0] ADR_EFR = 3'd2;
  localparam logic [2:0] ADR_LCR = 3'd3;
  localparam logic [2:0] ADR_DLF = 3'd7;
endpackage

// File: rtl/cfg_bank_decode.sv
module cfg_bank_decode
  import uart_cfg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY = 8'hBF
) (
  input  logic [DATA_W-1:0] lcr,
  input  logic [2:0]        addr,
  output mode_e             mode,
  output sel_e              sel
);
  always_comb begin
    if (lcr == KEY)              mode = MODE_KEY;
    else if (lcr[DATA_W-1])      mode = MODE_DIV;
    else                         mode = MODE_NORM;
  end

  always_comb begin
    sel = SEL_PASS;
    if (addr == ADR_LCR) begin
      sel = SEL_LCR;
    end else begin
      unique case (mode)
        MODE_KEY:  if (addr == ADR_EFR) sel = SEL_EFR;
        MODE_DIV: begin
          if (addr == ADR_DLL)      sel = SEL_DLL;
          else if (addr == ADR_DLH) sel = SEL_DLH;
          else if (addr == ADR_DLF) sel = SEL_DLF;
        end
        default:   sel = SEL_PASS;
      endcase
    end
  end
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import uart_cfg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAC_W  = 6,
  parameter int ENH_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lcr,
  output logic [DATA_W-1:0] efr,
  output logic [DATA_W-1:0] dll,
  output logic [DATA_W-1:0] dlh,
  output logic [FRAC_W-1:0] dlf,
  output logic              div_update
);
  logic enh;
  logic frac_ok;
  logic div_wr;

  assign enh     = efr[ENH_BIT];
  assign frac_ok = wr_en && (sel == SEL_DLF) && enh;
  assign div_wr  = wr_en && ((sel == SEL_DLL) || (sel == SEL_DLH) || frac_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr <= '0;
      efr <= '0;
      dll <= '0;
      dlh <= '0;
      dlf <= '0;
      div_update <= 1'b0;
    end else begin
      div_update <= div_wr;
      if (wr_en) begin
        unique case (sel)
          SEL_LCR: lcr <= wdata;
          SEL_EFR: efr <= wdata;
          SEL_DLL: dll <= wdata;
          SEL_DLH: dlh <= wdata;
          SEL_DLF: if (enh) dlf <= wdata[FRAC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assert_frac_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DLF && !efr[ENH_BIT]) |=> ($stable(dlf) && !div_update));
  assert_frac_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DLF && efr[ENH_BIT]) |=> (dlf == $past(wdata[FRAC_W-1:0])));
  assert_low_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DLL) |=> (dll == $past(wdata)));
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_update |=> !div_update || $past(wr_en));
endmodule

// File: rtl/uart_cfg_bank.sv
module uart_cfg_bank
  import uart_cfg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAC_W  = 6,
  parameter int ENH_BIT = 4,
  parameter logic [DATA_W-1:0] KEY = 8'hBF,
  localparam int DIV_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pt_wr,
  output logic              pt_rd,
  output logic [DATA_W-1:0] lcr_q,
  output logic              enh_en,
  output logic [DIV_W-1:0]  div_int,
  output logic [FRAC_W-1:0] div_frac,
  output logic              div_update
);
  mode_e mode;
  sel_e  sel;
  logic [DATA_W-1:0] efr_q, dll_q, dlh_q;

  cfg_bank_decode #(.DATA_W(DATA_W), .KEY(KEY)) u_dec (
    .lcr(lcr_q), .addr(addr), .mode(mode), .sel(sel)
  );

  cfg_reg_file #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ENH_BIT(ENH_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .lcr(lcr_q), .efr(efr_q), .dll(dll_q), .dlh(dlh_q), .dlf(div_frac),
    .div_update(div_update)
  );

  assign div_int = {dlh_q, dll_q};
  assign enh_en  = efr_q[ENH_BIT];
  assign pt_wr   = wr_en && (sel == SEL_PASS);
  assign pt_rd   = rd_en && (sel == SEL_PASS);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_LCR: rdata = lcr_q;
        SEL_EFR: rdata = efr_q;
        SEL_DLL: rdata = dll_q;
        SEL_DLH: rdata = dlh_q;
        SEL_DLF: rdata = DATA_W'(div_frac);
        default: rdata = '0;
      endcase
    end
  end

  assert_pass_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pt_wr |=> ($stable(div_int) && $stable(div_frac) && $stable(enh_en) && $stable(lcr_q)));
  assert_lcr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> (lcr_q == $past(wdata)));
  assert_pass_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd |-> (rdata == '0));
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pt_wr, pt_rd}));
endmodule

// File: tb/uart_cfg_bank_tb.sv
module uart_cfg_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, lcr_q;
  logic pt_wr, pt_rd, enh_en, div_update;
  logic [15:0] div_int;
  logic [5:0] div_frac;

  int checks = 0, failures = 0;
  logic last_pt_wr, last_pt_rd;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  uart_cfg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pt_wr(pt_wr), .pt_rd(pt_rd), .lcr_q(lcr_q),
    .enh_en(enh_en), .div_int(div_int), .div_frac(div_frac), .div_update(div_update)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); last_pt_wr = pt_wr;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
    @(posedge clk); #1; addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); last_pt_rd = pt_rd;
    @(posedge clk); #1; rd_en = 1'b0;
  endtask

  // monitor: pops expected read data while a read strobe is active
  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, {24'd0, rdata}, {24'd0, e});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 lcr", lcr_q, 0); chk("R1 div", div_int, 0);
    chk("R1 frac", div_frac, 0); chk("R1 enh", enh_en, 0);
    chk("R1 upd", div_update, 0);
    rd(3'd3, 8'h00, "R2 lcr read");
    // R7 normal bank pass-through
    wr(3'd0, 8'h55); chk("R7 pt_wr", last_pt_wr, 1); chk("R7 div", div_int, 0);
    chk("R7 upd", div_update, 0);
    rd(3'd2, 8'h00, "R10 pass rdata"); chk("R7 pt_rd", last_pt_rd, 1);
    // divisor bank
    wr(3'd3, 8'h93); chk("R2 lcr", lcr_q, 8'h93);
    wr(3'd7, 8'h10); chk("R6 frac", div_frac, 0); chk("R6 upd", div_update, 0);
    wr(3'd0, 8'h9C); chk("R9 upd", div_update, 1); chk("R4 div", div_int, 16'h009C);
    @(posedge clk); #1; chk("R9 one cycle", div_update, 0);
    wr(3'd1, 8'h00); chk("R9 upd hi", div_update, 1);
    rd(3'd0, 8'h9C, "R4 dll read");
    wr(3'd2, 8'h10); chk("R8 div bank addr2", last_pt_wr, 1); chk("R8 enh", enh_en, 0);
    // feature bank
    wr(3'd3, 8'hBF);
    wr(3'd2, 8'h10); chk("R3 enh", enh_en, 1); chk("R3 pt", last_pt_wr, 0);
    rd(3'd2, 8'h10, "R3 efr read");
    wr(3'd0, 8'h11); chk("R8 key addr0", last_pt_wr, 1); chk("R8 div", div_int, 16'h009C);
    // fractional write enabled
    wr(3'd3, 8'h93);
    wr(3'd7, 8'hD0); chk("R5 frac", div_frac, 6'h10); chk("R9 frac upd", div_update, 1);
    rd(3'd7, 8'h10, "R5 frac read");
    wr(3'd1, 8'h02); chk("R4 div hi", div_int, 16'h029C);
    // back to normal
    wr(3'd3, 8'h13); chk("R2 lcr", lcr_q, 8'h13);
    wr(3'd1, 8'hFF); chk("R7 div", div_int, 16'h029C); chk("R7 pt", last_pt_wr, 1);
    wr(3'd4, 8'hAA); chk("R8 addr4", last_pt_wr, 1);
    rd(3'd7, 8'h00, "R10 norm addr7"); chk("R7 pt_rd7", last_pt_rd, 1);
    rd(3'd3, 8'h13, "R2 lcr readback");
    chk("R5 frac kept", div_frac, 6'h10);
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule